// File: doc/BRIEF.md
# Integer ALU with Status Flags

A purely combinational integer arithmetic and logic unit for an execution stage. It works on byte, word or long operands. It does add, subtract, compare, increment, decrement, two's-complement negate, bitwise complement, AND, OR, XOR and a non-destructive AND (test). Each operation produces a size-masked result, a write-enable that says whether the result should be stored, and a 32-bit flags word.

The flags word is formed from the incoming flags word. Only the status bits that the operation is defined to update are replaced. Everything else passes through, apart from three architecturally fixed bits. The second operand can be an 8-bit immediate, which is sign-extended to the selected operand size instead of taking the register operand.

Top module: `alu_flags_core`

## Requirements
- R1: `op_size` selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. `result` holds the size-masked value, and bits above the selected width read 0.
- R2: The arithmetic results are taken modulo 2^width: ADD (`op_code` 0) a+b, SUB (1) a-b, INC (3) a+1, DEC (4) a-1 and NEG (5) 0-a.
- R3: Carry (flags bit 0) is the carry out of the operand's top bit for ADD, and the borrow into it for SUB, CMP and NEG. For NEG, carry is therefore set exactly when the operand is nonzero.
- R4: Overflow (flags bit 11) is set when the two's-complement result does not fit in the selected width.
- R5: Adjust (flags bit 4) is set on a carry out of bit 3 for additions, or a borrow into bit 3 for subtractions.
- R6: Zero (bit 6) is set when the size-masked value is 0. Sign (bit 7) is its top bit. Parity (bit 2) is set when bits 7:0 hold an even number of ones, at any width.
- R7: `flags_out` bit 1 is always 1, and bits 3 and 5 are always 0. Every bit outside {0,1,2,3,4,5,6,7,11} equals `flags_in`, as does every status bit the operation does not update.
- R8: INC and DEC update parity, adjust, zero, sign and overflow, but leave carry equal to `flags_in` bit 0.
- R9: CMP (`op_code` 2) sets the flags exactly as SUB would and drives `wr_en` low. `result` shows the difference.
- R10: TEST (`op_code` 10) ANDs the operands, sets zero, sign and parity from that value, clears carry, overflow and adjust, and drives `wr_en` low.
- R11: AND (7), OR (8) and XOR (9) write their result, set zero, sign and parity, and clear carry, overflow and adjust.
- R12: NOT (6) writes the complement of `src_a` within the width and leaves all flags equal to `flags_in` (apart from the fixed bits).
- R13: With `imm_sel` = 1, `imm_val` is sign-extended to the selected width and used as the second operand in place of `src_b`.
- R14: Any `op_code` above 10 gives `wr_en` = 0, `result` = 0 and no flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select (encoding in R2, R9-R12, R14) |
| op_size | input | 2 | Operand width select |
| imm_sel | input | 1 | Use the immediate as second operand |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand (register) |
| imm_val | input | 8 | Immediate, sign-extended to the width |
| flags_in | input | 32 | Current flags word |
| result | output | 32 | Size-masked result |
| wr_en | output | 1 | Result is to be stored |
| flags_out | output | 32 | Updated flags word |

## Verification
The bench builds the block with its defaults: three operand widths, an 8-bit immediate and a 32-bit flags word. With these defaults every width can be reached through `op_size`, including the clamp of code 3 onto 32 bits. Sign extension can be exercised from 8 bits up to both 16 and 32 bits. Carry and overflow can be driven at each of the three top-bit positions, and the adjust and parity bits stay at fixed positions whatever the width.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

   localparam int unsigned BASE_W = 8;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_CMP  = 4'd2,
      OP_INC  = 4'd3,
      OP_DEC  = 4'd4,
      OP_NEG  = 4'd5,
      OP_NOT  = 4'd6,
      OP_AND  = 4'd7,
      OP_OR   = 4'd8,
      OP_XOR  = 4'd9,
      OP_TEST = 4'd10
   } alu_op_e;

   localparam int unsigned POS_CF  = 0;
   localparam int unsigned POS_ONE = 1;
   localparam int unsigned POS_PF  = 2;
   localparam int unsigned POS_Z3  = 3;
   localparam int unsigned POS_AF  = 4;
   localparam int unsigned POS_Z5  = 5;
   localparam int unsigned POS_ZF  = 6;
   localparam int unsigned POS_SF  = 7;
   localparam int unsigned POS_OF  = 11;

   typedef struct packed {
      logic cf;
      logic pf;
      logic af;
      logic zf;
      logic sf;
      logic of;
   } stat_bits_t;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
   parameter int NUM_SIZES = 3,
   parameter int IMM_W     = 8,
   localparam int DATA_W   = alu_flags_pkg::BASE_W << (NUM_SIZES - 1)
) (
   input  logic [1:0]        op_size,
   input  logic              imm_sel,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm_val,
   output logic [1:0]        sz_idx,
   output logic [DATA_W-1:0] size_mask,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);
   import alu_flags_pkg::*;

   logic [DATA_W-1:0] imm_ext;
   int unsigned       width_sel;

   always_comb begin
      if (32'(op_size) >= 32'(NUM_SIZES)) sz_idx = 2'(NUM_SIZES - 1);
      else                                sz_idx = op_size;
      width_sel = BASE_W << sz_idx;
      size_mask = {DATA_W{1'b1}} >> (DATA_W - width_sel);
   end

   assign imm_ext = DATA_W'(signed'(imm_val));
   assign opnd_a  = src_a & size_mask;
   assign opnd_b  = (imm_sel ? imm_ext : src_b) & size_mask;

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int NUM_SIZES = 3,
   localparam int DATA_W   = alu_flags_pkg::BASE_W << (NUM_SIZES - 1)
) (
   input  logic [1:0]        sz_idx,
   input  logic [DATA_W-1:0] add_a,
   input  logic [DATA_W-1:0] add_b,
   input  logic              do_sub,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              adjust,
   output logic              ovf
);
   import alu_flags_pkg::*;

   logic [DATA_W-1:0] b_inv;
   logic [DATA_W-1:0] lane_sum [NUM_SIZES];
   logic              lane_co  [NUM_SIZES];
   logic              lane_ov  [NUM_SIZES];

   assign b_inv = do_sub ? ~add_b : add_b;

   for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_lane
      localparam int LW = BASE_W << gi;
      logic [LW:0] wide;
      assign wide         = {1'b0, add_a[LW-1:0]} + {1'b0, b_inv[LW-1:0]} + {{LW{1'b0}}, do_sub};
      assign lane_sum[gi] = DATA_W'(wide[LW-1:0]);
      assign lane_co[gi]  = wide[LW];
      assign lane_ov[gi]  = (add_a[LW-1] == b_inv[LW-1]) && (wide[LW-1] != add_a[LW-1]);
   end

   assign sum    = lane_sum[sz_idx];
   assign carry  = lane_co[sz_idx] ^ do_sub;
   assign ovf    = lane_ov[sz_idx];
   assign adjust = add_a[4] ^ add_b[4] ^ sum[4];

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge #(
   parameter int FLAGS_W = 32
) (
   input  logic [FLAGS_W-1:0]      flags_in,
   input  alu_flags_pkg::stat_bits_t new_bits,
   input  alu_flags_pkg::stat_bits_t upd_bits,
   output logic [FLAGS_W-1:0]      flags_out
);
   import alu_flags_pkg::*;

   always_comb begin
      flags_out = flags_in;
      if (upd_bits.cf) flags_out[POS_CF] = new_bits.cf;
      if (upd_bits.pf) flags_out[POS_PF] = new_bits.pf;
      if (upd_bits.af) flags_out[POS_AF] = new_bits.af;
      if (upd_bits.zf) flags_out[POS_ZF] = new_bits.zf;
      if (upd_bits.sf) flags_out[POS_SF] = new_bits.sf;
      if (upd_bits.of) flags_out[POS_OF] = new_bits.of;
      flags_out[POS_ONE] = 1'b1;
      flags_out[POS_Z3]  = 1'b0;
      flags_out[POS_Z5]  = 1'b0;
   end

endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core #(
   parameter int NUM_SIZES = 3,
   parameter int IMM_W     = 8,
   parameter int FLAGS_W   = 32,
   localparam int DATA_W   = alu_flags_pkg::BASE_W << (NUM_SIZES - 1)
) (
   input  logic [3:0]         op_code,
   input  logic [1:0]         op_size,
   input  logic               imm_sel,
   input  logic [DATA_W-1:0]  src_a,
   input  logic [DATA_W-1:0]  src_b,
   input  logic [IMM_W-1:0]   imm_val,
   input  logic [FLAGS_W-1:0] flags_in,
   output logic [DATA_W-1:0]  result,
   output logic               wr_en,
   output logic [FLAGS_W-1:0] flags_out
);
   import alu_flags_pkg::*;

   if (NUM_SIZES < 1 || NUM_SIZES > 3) begin : g_bad_sizes
      $error("NUM_SIZES must be 1..3");
   end
   if (IMM_W < 1 || IMM_W > BASE_W) begin : g_bad_imm
      $error("IMM_W must be 1..8");
   end
   if (FLAGS_W < POS_OF + 1) begin : g_bad_flags
      $error("FLAGS_W too small for the overflow position");
   end

   alu_op_e           op;
   logic [1:0]        sz_idx;
   logic [DATA_W-1:0] size_mask, opnd_a, opnd_b;
   logic [DATA_W-1:0] add_a, add_b, sum;
   logic              do_sub, carry, adjust, ovf;
   logic [DATA_W-1:0] val;
   logic              val_top;
   stat_bits_t        new_bits, upd_bits;

   assign op = alu_op_e'(op_code);

   alu_operand_sel #(.NUM_SIZES(NUM_SIZES), .IMM_W(IMM_W)) opsel_i (
      .op_size  (op_size),
      .imm_sel  (imm_sel),
      .src_a    (src_a),
      .src_b    (src_b),
      .imm_val  (imm_val),
      .sz_idx   (sz_idx),
      .size_mask(size_mask),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b)
   );

   always_comb begin
      add_a  = opnd_a;
      add_b  = opnd_b;
      do_sub = 1'b0;
      unique case (op)
         OP_SUB, OP_CMP: do_sub = 1'b1;
         OP_INC:         add_b  = DATA_W'(1);
         OP_DEC: begin
            add_b  = DATA_W'(1);
            do_sub = 1'b1;
         end
         OP_NEG: begin
            add_a  = '0;
            add_b  = opnd_a;
            do_sub = 1'b1;
         end
         default: ;
      endcase
   end

   alu_addsub #(.NUM_SIZES(NUM_SIZES)) addsub_i (
      .sz_idx(sz_idx),
      .add_a (add_a),
      .add_b (add_b),
      .do_sub(do_sub),
      .sum   (sum),
      .carry (carry),
      .adjust(adjust),
      .ovf   (ovf)
   );

   always_comb begin
      val      = '0;
      wr_en    = 1'b0;
      upd_bits = '0;
      unique case (op)
         OP_ADD, OP_SUB, OP_NEG: begin
            val      = sum;
            wr_en    = 1'b1;
            upd_bits = '1;
         end
         OP_CMP: begin
            val      = sum;
            upd_bits = '1;
         end
         OP_INC, OP_DEC: begin
            val         = sum;
            wr_en       = 1'b1;
            upd_bits    = '1;
            upd_bits.cf = 1'b0;
         end
         OP_NOT: begin
            val   = ~opnd_a & size_mask;
            wr_en = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            val      = (op == OP_AND) ? (opnd_a & opnd_b) :
                       (op == OP_OR)  ? (opnd_a | opnd_b) : (opnd_a ^ opnd_b);
            wr_en    = 1'b1;
            upd_bits = '1;
         end
         OP_TEST: begin
            val      = opnd_a & opnd_b;
            upd_bits = '1;
         end
         default: ;
      endcase
   end

   assign val_top = val[(BASE_W << sz_idx) - 1];

   always_comb begin
      new_bits.pf = ~^val[BASE_W-1:0];
      new_bits.zf = (val == '0);
      new_bits.sf = val_top;
      if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_TEST) begin
         new_bits.cf = 1'b0;
         new_bits.af = 1'b0;
         new_bits.of = 1'b0;
      end else begin
         new_bits.cf = carry;
         new_bits.af = adjust;
         new_bits.of = ovf;
      end
   end

   alu_flag_merge #(.FLAGS_W(FLAGS_W)) merge_i (
      .flags_in (flags_in),
      .new_bits (new_bits),
      .upd_bits (upd_bits),
      .flags_out(flags_out)
   );

   assign result = val;

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
   parameter int NUM_SIZES = 3,
   parameter int FLAGS_W   = 32,
   localparam int DATA_W   = alu_flags_pkg::BASE_W << (NUM_SIZES - 1)
) (
   input logic [3:0]         op_code,
   input logic [1:0]         op_size,
   input logic [FLAGS_W-1:0] flags_in,
   input logic [DATA_W-1:0]  result,
   input logic               wr_en,
   input logic [FLAGS_W-1:0] flags_out
);
   logic flagged_val;
   assign flagged_val = (op_code <= 4'd5) || (op_code >= 4'd7 && op_code <= 4'd10);

   always_comb begin
      p_fixed_bits_r7: assert (flags_out[1] && !flags_out[3] && !flags_out[5])
         else $error("fixed flag bits wrong");
      if (op_code == 4'd2)
         p_cmp_no_write_r9: assert (!wr_en) else $error("compare wrote");
      if (op_code == 4'd10)
         p_test_no_write_r10: assert (!wr_en) else $error("test wrote");
      if (op_code == 4'd3 || op_code == 4'd4)
         p_keep_carry_r8: assert (flags_out[0] == flags_in[0]) else $error("carry moved");
      if (op_code == 4'd6)
         p_not_flags_r12: assert (((flags_out ^ flags_in) & ~FLAGS_W'(32'h2A)) == '0)
            else $error("not touched flags");
      if (op_code >= 4'd7 && op_code <= 4'd10)
         p_logic_clear_r11: assert (!flags_out[0] && !flags_out[4] && !flags_out[11])
            else $error("logic op left cf/af/of");
      if (flagged_val)
         p_zero_r6: assert (flags_out[6] == (result == '0)) else $error("zero flag");
      if (flagged_val)
         p_parity_r6: assert (flags_out[2] == ~^result[7:0]) else $error("parity flag");
      if (op_code > 4'd10)
         p_undef_r14: assert (!wr_en && result == '0) else $error("undefined op acted");
      if (op_size == 2'd0)
         p_upper_zero_r1: assert ((result >> 8) == '0) else $error("byte upper bits");
   end

endmodule

bind alu_flags_core alu_flags_chk #(.NUM_SIZES(NUM_SIZES), .FLAGS_W(FLAGS_W)) chk_i (
   .op_code  (op_code),
   .op_size  (op_size),
   .flags_in (flags_in),
   .result   (result),
   .wr_en    (wr_en),
   .flags_out(flags_out)
);

// File: tb/alu_flags_core_tb_top.sv
module alu_flags_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_code = '0;
   logic [1:0]  op_size = '0;
   logic        imm_sel = 1'b0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [7:0]  imm_val = '0;
   logic [31:0] flags_in = '0;
   logic [31:0] result;
   logic        wr_en;
   logic [31:0] flags_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   alu_flags_core dut_i (
      .op_code  (op_code),
      .op_size  (op_size),
      .imm_sel  (imm_sel),
      .src_a    (src_a),
      .src_b    (src_b),
      .imm_val  (imm_val),
      .flags_in (flags_in),
      .result   (result),
      .wr_en    (wr_en),
      .flags_out(flags_out)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [1:0]  sz;
      logic        isel;
      logic [31:0] a;
      logic [31:0] b;
      logic [7:0]  imm;
      logic [31:0] res;
      logic        we;
      logic [31:0] fl;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{4'd0,  2'd0, 1'b0, 32'hAAAA_AAFF, 32'h5555_5501, 8'h00, 32'h0000_0000, 1'b1, 32'h57},
      '{4'd0,  2'd0, 1'b0, 32'h0000_007F, 32'h0000_0001, 8'h00, 32'h0000_0080, 1'b1, 32'h892},
      '{4'd0,  2'd1, 1'b0, 32'h0000_8000, 32'h0000_8000, 8'h00, 32'h0000_0000, 1'b1, 32'h847},
      '{4'd1,  2'd2, 1'b0, 32'h0000_0000, 32'h0000_0001, 8'h00, 32'hFFFF_FFFF, 1'b1, 32'h97},
      '{4'd1,  2'd2, 1'b0, 32'h8000_0000, 32'h0000_0001, 8'h00, 32'h7FFF_FFFF, 1'b1, 32'h816},
      '{4'd2,  2'd1, 1'b0, 32'h0000_0005, 32'h0000_0005, 8'h00, 32'h0000_0000, 1'b0, 32'h46},
      '{4'd2,  2'd0, 1'b0, 32'h0000_0003, 32'h0000_0005, 8'h00, 32'h0000_00FE, 1'b0, 32'h93},
      '{4'd3,  2'd1, 1'b0, 32'h0000_FFFF, 32'h0000_0000, 8'h00, 32'h0000_0000, 1'b1, 32'h56},
      '{4'd4,  2'd2, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'h00, 32'hFFFF_FFFF, 1'b1, 32'h96},
      '{4'd5,  2'd0, 1'b0, 32'h0000_0080, 32'h0000_0000, 8'h00, 32'h0000_0080, 1'b1, 32'h883},
      '{4'd5,  2'd1, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'h00, 32'h0000_0000, 1'b1, 32'h46},
      '{4'd5,  2'd0, 1'b0, 32'h0000_0001, 32'h0000_0000, 8'h00, 32'h0000_00FF, 1'b1, 32'h97},
      '{4'd7,  2'd2, 1'b0, 32'hF0F0_1234, 32'h0FF0_FFFF, 8'h00, 32'h00F0_1234, 1'b1, 32'h2},
      '{4'd8,  2'd0, 1'b0, 32'h0000_0080, 32'h0000_0001, 8'h00, 32'h0000_0081, 1'b1, 32'h86},
      '{4'd9,  2'd1, 1'b0, 32'h0000_AAAA, 32'h0000_AAAA, 8'h00, 32'h0000_0000, 1'b1, 32'h46},
      '{4'd10, 2'd2, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 8'h00, 32'h8000_0000, 1'b0, 32'h86},
      '{4'd6,  2'd0, 1'b0, 32'h0000_000F, 32'h0000_0000, 8'h00, 32'h0000_00F0, 1'b1, 32'h2},
      '{4'd0,  2'd0, 1'b1, 32'h0000_0010, 32'h0000_0055, 8'hFF, 32'h0000_000F, 1'b1, 32'h7},
      '{4'd1,  2'd1, 1'b1, 32'h0000_0000, 32'h0000_0000, 8'h80, 32'h0000_0080, 1'b1, 32'h3},
      '{4'd0,  2'd2, 1'b1, 32'h0000_0100, 32'h0000_0000, 8'h80, 32'h0000_0080, 1'b1, 32'h3},
      '{4'd15, 2'd0, 1'b0, 32'h0000_1234, 32'h0000_0001, 8'h00, 32'h0000_0000, 1'b0, 32'h2},
      '{4'd0,  2'd3, 1'b0, 32'h0000_FFFF, 32'h0000_0001, 8'h00, 32'h0001_0000, 1'b1, 32'h16}
   };

   string tags [NV];

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [1:0] sz, input logic isel,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [7:0] imm, input logic [31:0] fin);
      @(posedge clk);
      op_code  = op;
      op_size  = sz;
      imm_sel  = isel;
      src_a    = a;
      src_b    = b;
      imm_val  = imm;
      flags_in = fin;
      @(negedge clk);
   endtask

   initial begin
      tags = '{"R1 R2 R3 R5 R6", "R4 R6", "R3 R4", "R2 R3 R5", "R4",
               "R9", "R9 R3", "R8", "R8", "R3 R4", "R3", "R3 R5",
               "R11", "R11 R6", "R11", "R10", "R12", "R13", "R13", "R13",
               "R14", "R1"};
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: all-zero inputs select a byte ADD of 0+0 (R6, R7)
      chk("R6", "reset result", result, 32'h0);
      chk("R7", "reset flags", flags_out, 32'h46);
      chk("R2", "reset wr_en", 32'(wr_en), 32'h1);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].op, VECS[i].sz, VECS[i].isel, VECS[i].a, VECS[i].b,
               VECS[i].imm, 32'h0);
         chk(tags[i], "result", result, VECS[i].res);
         chk(tags[i], "wr_en", 32'(wr_en), 32'(VECS[i].we));
         chk(tags[i], "flags", flags_out, VECS[i].fl);
      end

      // R12 R7: NOT leaves every flag alone, fixed bits still forced
      apply(4'd6, 2'd0, 1'b0, 32'h0F, 32'h0, 8'h0, 32'hFFFF_FFFF);
      chk("R12", "not flags passthrough", flags_out, 32'hFFFF_FFD7);
      // R8: increment keeps an incoming carry of 1
      apply(4'd3, 2'd0, 1'b0, 32'h01, 32'h0, 8'h0, 32'h0000_0001);
      chk("R8", "inc result", result, 32'h02);
      chk("R8", "inc keeps carry", flags_out, 32'h3);
      // R7: only the six status bits change, other bits pass through
      apply(4'd0, 2'd0, 1'b0, 32'h01, 32'h01, 8'h0, 32'hFFFF_FFFF);
      chk("R7", "add merge", flags_out, 32'hFFFF_F702);
      // R10: test clears incoming carry, adjust and overflow
      apply(4'd10, 2'd0, 1'b0, 32'h0F, 32'hF0, 8'h0, 32'h0000_0811);
      chk("R10", "test flags", flags_out, 32'h46);
      chk("R10", "test wr_en", 32'(wr_en), 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule